// File: doc/BRIEF.md
# Programmable Field Vertical Sync Placement

The block produces the vertical sync level for an interlaced 525-line raster. For every field it works out the line, and the point within that line, where the pulse starts and where it ends. Each edge starts from a fixed nominal line for the current field. A signed offset moves it, an optional one-line delay for that field can push it one line later, and an optional half-line advance for that field can pull it half a line earlier. The raster timing comes from outside: a line counter, a pixel counter, a field flag and the programmed number of pixels per line.

Software programs three byte-wide control registers through a plain write port. A write lands in a staging copy. The staging copy moves into the working copy when the field flag changes, so a pulse that is already running always finishes with the settings it started with. The block drives two registered outputs, the sync pin level and the vertical flag used in embedded timing codes. Both are updated on the same clock edge and always carry the same value.

Top module: `vsync_placer`

## Requirements
- R1: After reset `vs_out` and `v_flag` are 0. The working registers hold begin = 0x25, end = 0x00 and half-line = 0x00, which place the pulse from line 3 to line 9 in the odd field and from line 266 to line 272 in the even field.
- R2: Begin register layout (`cfg_sel` = 0): bits 4:0 hold the offset and bit 5 holds the sign. The begin line is the nominal begin line (8 odd, 271 even) plus the offset when the sign is 0, or minus the offset when the sign is 1. `vs_out` goes to 1 on the clock edge at which the counters equal that position, so it is seen in the following cycle.
- R3: In the begin and end registers, bit 7 adds one line while `field_odd` = 1 and bit 6 adds one line while `field_odd` = 0.
- R4: The end register (`cfg_sel` = 1) uses the same layout as the begin register, with nominal end lines 9 (odd) and 272 (even). It is independent of the begin register. `vs_out` goes to 0 at the end position.
- R5: Half-line register (`cfg_sel` = 2): bit 0 is begin-odd, bit 1 is begin-even, bit 2 is end-odd and bit 3 is end-even. When the bit for the current field is set, that edge happens at pixel `h_total`/2 of the line before the computed line. Otherwise the edge happens at pixel 0 of the computed line.
- R6: Edge lines wrap modulo 525. For example, begin 0x3F in an odd field places the rise at line 502.
- R7: `v_flag` equals `vs_out` in every cycle.
- R8: A write changes only the staging copy. The working copy takes the new value at the clock edge where `field_odd` differs from its value in the previous cycle.
- R9: When the begin and end positions fall on the same cycle, `vs_out` is 0 afterwards, because the end edge wins.
- R10: A write with `cfg_sel` = 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_cnt | input | 10 | Current line, 0 to 524 |
| pix_cnt | input | 11 | Current pixel within the line |
| h_total | input | 11 | Pixels per line |
| field_odd | input | 1 | 1 while the odd field is active |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 begin, 1 end, 2 half-line, 3 none |
| cfg_wdata | input | 8 | Write data |
| vs_out | output | 1 | Vertical sync pin level |
| v_flag | output | 1 | Vertical flag for embedded timing codes |

## Verification
The begin and end edges can fall on the same cycle. The bench provokes this by programming an end advance that lands exactly on the begin position in both fields. It then judges the result by confirming that no rising edge appears across a whole frame. A second collision is a register write in the same cycle as a field change. The assertions check this case by requiring that the working copy changes only one edge after a field flag transition.

// File: rtl/vsp_pkg.sv
package vsp_pkg;

  typedef struct packed {
    logic       dly_odd;
    logic       dly_even;
    logic       adv;
    logic [4:0] off;
  } edge_reg_t;

  typedef enum logic [1:0] {
    SEL_BEG  = 2'd0,
    SEL_END  = 2'd1,
    SEL_HALF = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  localparam edge_reg_t BEG_RST  = 8'h25;
  localparam edge_reg_t END_RST  = 8'h00;
  localparam logic [3:0] HALF_RST = 4'h0;

endpackage

// File: rtl/vsp_cfg_regs.sv
module vsp_cfg_regs
  import vsp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            field_odd,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [7:0]      cfg_wdata,
  output edge_reg_t       act_beg,
  output edge_reg_t       act_end,
  output logic [3:0]      act_half
);

  edge_reg_t  stg_beg, stg_end;
  logic [3:0] stg_half;
  logic       field_q;
  logic       field_flip;

  assign field_flip = field_odd ^ field_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_beg  <= BEG_RST;
      stg_end  <= END_RST;
      stg_half <= HALF_RST;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_BEG:  stg_beg  <= edge_reg_t'(cfg_wdata);
        SEL_END:  stg_end  <= edge_reg_t'(cfg_wdata);
        SEL_HALF: stg_half <= cfg_wdata[3:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q  <= 1'b1;
      act_beg  <= BEG_RST;
      act_end  <= END_RST;
      act_half <= HALF_RST;
    end else begin
      field_q <= field_odd;
      if (field_flip) begin
        act_beg  <= stg_beg;
        act_end  <= stg_end;
        act_half <= stg_half;
      end
    end
  end

endmodule

// File: rtl/vsp_edge_pos.sv
module vsp_edge_pos
  import vsp_pkg::*;
#(
  parameter int LINE_W      = 10,
  parameter int PIX_W       = 11,
  parameter int FRAME_LINES = 525,
  parameter int NOM_ODD     = 8,
  parameter int NOM_EVEN    = 271
) (
  input  edge_reg_t           ctl,
  input  logic                half_odd,
  input  logic                half_even,
  input  logic                field_odd,
  input  logic [LINE_W-1:0]   line_cnt,
  input  logic [PIX_W-1:0]    pix_cnt,
  input  logic [PIX_W-1:0]    h_total,
  output logic                hit
);

  localparam int SW = LINE_W + 2;
  localparam logic signed [SW-1:0] NOM_O = SW'(NOM_ODD);
  localparam logic signed [SW-1:0] NOM_E = SW'(NOM_EVEN);
  localparam logic signed [SW-1:0] FR    = SW'(FRAME_LINES);
  localparam logic signed [SW-1:0] ONE   = SW'(1);
  localparam logic signed [SW-1:0] ZERO  = SW'(0);

  logic signed [SW-1:0] pos;
  logic signed [SW-1:0] off_s;
  logic                 use_dly, use_half;
  logic [LINE_W-1:0]    line_tgt;
  logic [PIX_W-1:0]     pix_tgt;

  always_comb begin
    use_dly  = field_odd ? ctl.dly_odd : ctl.dly_even;
    use_half = field_odd ? half_odd : half_even;
    off_s    = $signed({{(SW-5){1'b0}}, ctl.off});
    pos      = field_odd ? NOM_O : NOM_E;
    if (ctl.adv) pos = pos - off_s;
    else         pos = pos + off_s;
    if (use_dly)  pos = pos + ONE;
    if (use_half) pos = pos - ONE;
    if (pos < ZERO)     pos = pos + FR;
    else if (pos >= FR) pos = pos - FR;
    line_tgt = pos[LINE_W-1:0];
    pix_tgt  = use_half ? (h_total >> 1) : '0;
  end

  assign hit = (line_cnt == line_tgt) && (pix_cnt == pix_tgt);

endmodule

// File: rtl/vsync_placer.sv
module vsync_placer
  import vsp_pkg::*;
#(
  parameter int LINE_W       = 10,
  parameter int PIX_W        = 11,
  parameter int FRAME_LINES  = 525,
  parameter int NOM_BEG_ODD  = 8,
  parameter int NOM_BEG_EVEN = 271,
  parameter int NOM_END_ODD  = 9,
  parameter int NOM_END_EVEN = 272
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [PIX_W-1:0]  pix_cnt,
  input  logic [PIX_W-1:0]  h_total,
  input  logic              field_odd,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic              vs_out,
  output logic              v_flag
);

  localparam int N_EDGE = 2;

  edge_reg_t        act_beg, act_end;
  logic [3:0]       act_half;
  logic [N_EDGE-1:0] hit;
  logic             hit_beg, hit_end;
  logic             vs_next;

  vsp_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .field_odd (field_odd),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .act_beg   (act_beg),
    .act_end   (act_end),
    .act_half  (act_half)
  );

  for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
    vsp_edge_pos #(
      .LINE_W      (LINE_W),
      .PIX_W       (PIX_W),
      .FRAME_LINES (FRAME_LINES),
      .NOM_ODD     (g == 0 ? NOM_BEG_ODD  : NOM_END_ODD),
      .NOM_EVEN    (g == 0 ? NOM_BEG_EVEN : NOM_END_EVEN)
    ) u_pos (
      .ctl       (g == 0 ? act_beg : act_end),
      .half_odd  (act_half[2*g]),
      .half_even (act_half[2*g+1]),
      .field_odd (field_odd),
      .line_cnt  (line_cnt),
      .pix_cnt   (pix_cnt),
      .h_total   (h_total),
      .hit       (hit[g])
    );
  end

  assign hit_beg = hit[0];
  assign hit_end = hit[1];

  always_comb begin
    vs_next = vs_out;
    if (hit_beg) vs_next = 1'b1;
    if (hit_end) vs_next = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_out <= 1'b0;
      v_flag <= 1'b0;
    end else begin
      vs_out <= vs_next;
      v_flag <= vs_next;
    end
  end

endmodule

// File: rtl/vsp_chk.sv
module vsp_chk
  import vsp_pkg::*;
#(
  parameter int PIX_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PIX_W-1:0] pix_cnt,
  input logic [PIX_W-1:0] h_total,
  input logic             field_odd,
  input logic             hit_beg,
  input logic             hit_end,
  input edge_reg_t        act_beg,
  input logic             vs_out,
  input logic             v_flag
);

  AST_FLAGS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    v_flag == vs_out); // R7

  AST_END_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_beg && hit_end |=> !vs_out); // R9

  AST_BEGIN_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    hit_beg && !hit_end |=> vs_out); // R2

  AST_EDGE_ON_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vs_out) |-> ($past(pix_cnt) == '0 || $past(pix_cnt) == ($past(h_total) >> 1))); // R5

  AST_LOAD_AT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_beg) && $past(rst_n, 2) |-> $past(field_odd) != $past(field_odd, 2)); // R8

endmodule

bind vsync_placer vsp_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_cnt   (pix_cnt),
  .h_total   (h_total),
  .field_odd (field_odd),
  .hit_beg   (hit_beg),
  .hit_end   (hit_end),
  .act_beg   (act_beg),
  .vs_out    (vs_out),
  .v_flag    (v_flag)
);

// File: tb/sim_vsync_placer.sv
module sim_vsync_placer;

  localparam int HT     = 12;
  localparam int FRAME  = 525;
  localparam int NCYC   = FRAME * HT;
  localparam int NV     = 6;
  // beg, end, half, odd rise L/P, odd fall L/P, even rise L/P, even fall L/P
  localparam int VEC [NV][11] = '{
    '{8'h25, 8'h00, 8'h00,   3, 0,  9, 0, 266, 0, 272, 0},  // R1 R10
    '{8'h03, 8'h04, 8'h00,  11, 0, 13, 0, 274, 0, 276, 0},  // R2 R4
    '{8'hE1, 8'h03, 8'h00,   8, 0, 12, 0, 271, 0, 275, 0},  // R3
    '{8'h25, 8'h00, 8'h05,   2, 6,  8, 6, 266, 0, 272, 0},  // R5 odd
    '{8'hA5, 8'h40, 8'h0A,   4, 0,  9, 0, 265, 6, 272, 6},  // R3 R5 even
    '{8'h1F, 8'h1F, 8'h00,  39, 0, 40, 0, 302, 0, 303, 0}   // R2 R4 max
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  line_cnt = '0;
  logic [10:0] pix_cnt = '0;
  logic [10:0] h_total = 11'(HT);
  logic        field_odd = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        vs_out, v_flag;

  int total = 0, bad = 0;
  bit done = 0;
  bit force_odd = 0;
  bit vs_prev = 0;
  int vf_mis = 0, rises = 0;
  int orl, orp, ofl, ofp, erl, erp, efl, efp;

  always #5 clk = ~clk;

  vsync_placer u0 (
    .clk(clk), .rst_n(rst_n), .line_cnt(line_cnt), .pix_cnt(pix_cnt),
    .h_total(h_total), .field_odd(field_odd), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .vs_out(vs_out), .v_flag(v_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_rec();
    orl = 999; orp = 999; ofl = 999; ofp = 999;
    erl = 999; erp = 999; efl = 999; efp = 999;
    rises = 0;
  endtask

  task automatic step();
    @(negedge clk);
    if (v_flag != vs_out) vf_mis++;
    if (vs_out && !vs_prev) begin
      rises++;
      if (field_odd) begin orl = int'(line_cnt); orp = int'(pix_cnt); end
      else           begin erl = int'(line_cnt); erp = int'(pix_cnt); end
    end
    if (!vs_out && vs_prev) begin
      if (field_odd) begin ofl = int'(line_cnt); ofp = int'(pix_cnt); end
      else           begin efl = int'(line_cnt); efp = int'(pix_cnt); end
    end
    vs_prev = vs_out;
    if (int'(pix_cnt) == HT - 1) begin
      pix_cnt = '0;
      line_cnt = (int'(line_cnt) == FRAME - 1) ? '0 : line_cnt + 10'd1;
    end else begin
      pix_cnt = pix_cnt + 11'd1;
    end
    field_odd = force_odd ? 1'b1 : (line_cnt < 10'd263);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    clear_rec();
    repeat (3) @(negedge clk);
    chk("R1 vs_out reset", int'(vs_out), 0);
    chk("R1 v_flag reset", int'(v_flag), 0);
    rst_n = 1'b1;

    // R8: write mid-field before the rise; old setting must hold this field
    run(HT);                       // now at line 1
    wr(2'd0, 8'h03);
    run(20 * HT);
    chk("R8 rise line before field change", orl, 3);
    chk("R1 default odd fall line", ofl, 9);

    for (int v = 0; v < NV; v++) begin
      wr(2'd0, 8'(VEC[v][0]));
      wr(2'd1, 8'(VEC[v][1]));
      wr(2'd2, 8'(VEC[v][2]));
      if (v == 0) wr(2'd3, 8'hFF); // R10 ignored select
      run(NCYC);
      clear_rec();
      run(NCYC);
      chk($sformatf("R2-vec%0d odd rise", v), orl * 100 + orp, VEC[v][3] * 100 + VEC[v][4]);
      chk($sformatf("R4-vec%0d odd fall", v), ofl * 100 + ofp, VEC[v][5] * 100 + VEC[v][6]);
      chk($sformatf("R3-vec%0d even rise", v), erl * 100 + erp, VEC[v][7] * 100 + VEC[v][8]);
      chk($sformatf("R5-vec%0d even fall", v), efl * 100 + efp, VEC[v][9] * 100 + VEC[v][10]);
    end

    // R9: end advanced onto the begin position in both fields
    wr(2'd0, 8'h25);
    wr(2'd1, 8'h26);
    wr(2'd2, 8'h00);
    run(NCYC);
    clear_rec();
    run(NCYC);
    chk("R9 coincident edges give no rise", rises, 0);
    chk("R9 output low", int'(vs_out), 0);

    // R6: advance 31 from odd nominal 8 wraps to line 502
    wr(2'd0, 8'h3F);
    wr(2'd1, 8'h00);
    run(NCYC);
    force_odd = 1;
    run(NCYC / 2);
    clear_rec();
    run(NCYC);
    chk("R6 wrapped rise line", orl * 100 + orp, 50200);

    chk("R7 v_flag tracks vs_out", vf_mis, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule